// File: doc/BRIEF.md
# TLB Fill Unit

This block holds a 64-slot address-translation buffer, each slot pairing a 64-bit tag with a 64-bit translation entry, next to a small bank of MMU control registers. Software fills the buffer with alternate-space stores. An automatic-fill store picks its own slot through a replacement search that takes an empty slot before an unlocked one. A direct-slot store writes the slot named by the address. In both cases the stored tag is the current content of the tag-staging register. The block also keeps the fault-status and fault-address registers, which a fault reporter loads and software clears. It also keeps the MMU enable bits, and changing them asks the rest of the MMU to flush every cached translation.

A request is one cycle wide: a space number, a doubleword address, write data, a write flag and a privilege flag. The block returns a trap pulse, a load-data strobe with data and a flush-all pulse, each one cycle after the request. Any space below 0x80 is privileged. An unprivileged access to such a space traps and has no effect.

Top module: `tlb_fill_unit`

## Requirements
- R1: After reset every translation entry, tag, control register and the enable state read as zero, so every slot is invalid.
- R2: A store to space 0x5C writes its data as the translation entry of the lowest-indexed slot whose bit 63 (valid) is clear. The slot's tag is set to control register 6.
- R3: If all slots are valid, a store to space 0x5C writes the lowest-indexed slot whose bit 6 (lock) is clear, with the tag from register 6.
- R4: If all slots are valid and locked, a store to space 0x5C changes no slot.
- R5: A store to space 0x5D writes the translation entry of slot address[8:3] and sets its tag to register 6. A load from 0x5D returns that slot's entry, and a load from 0x5E returns its tag.
- R6: Space 0x58 reaches 16 control registers indexed by address[6:3]. Stores to registers 0 and 4 are ignored, stores to the other registers replace their value, and loads return the current value.
- R7: A store to register 3 with data bit 0 clear sets registers 3 and 4 to zero. With bit 0 set, the store writes the data into register 3 and leaves register 4 unchanged.
- R8: Any access to a space below 0x80 with the privilege flag low raises trap_o in the next cycle. It changes no state and produces no load strobe.
- R9: A store to space 0x45 keeps only data bits 3 and 2 as the enable state. flush_all_o pulses in the next cycle exactly when the kept value differs from the previous one, and a load from 0x45 returns the state.
- R10: fault_set_i loads register 3 from fault_status_i and register 4 from fault_addr_i. It takes precedence over a store to either register in the same cycle.
- R11: A load that does not trap raises rvalid_o with rdata_o in the next cycle. Spaces other than 0x45, 0x58, 0x5D and 0x5E return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_space_i | input | 8 | Alternate space number |
| req_addr_i | input | 6 | Doubleword address bits 8:3 |
| req_wdata_i | input | 64 | Store data |
| req_priv_i | input | 1 | Requester is privileged |
| fault_set_i | input | 1 | Record a fault this cycle |
| fault_status_i | input | 64 | Fault status to record |
| fault_addr_i | input | 64 | Fault address to record |
| trap_o | output | 1 | Privileged-access trap pulse |
| rvalid_o | output | 1 | Load data valid |
| rdata_o | output | 64 | Load data |
| flush_all_o | output | 1 | Flush-all request pulse |

## Verification
Fault capture and a software store to the fault-status register can land in the same cycle. The bench provokes this by raising fault_set_i while it issues a clearing store to register 3, and also while it stores to the unrelated register 5. A behavioural model applies the store first and the capture after it. The readback of registers 3, 4 and 5 must show the captured fault together with the unrelated write. The replacement corner cases are driven in the same way: buffers that are partly empty, full with a locked prefix, and full and locked. Every output is compared with the model on every clock.

// File: rtl/tlb_fill_pkg.sv
package tlb_fill_pkg;
  localparam logic [7:0] SPC_LSU_CTL = 8'h45;
  localparam logic [7:0] SPC_REGS    = 8'h58;
  localparam logic [7:0] SPC_AUTO    = 8'h5C;
  localparam logic [7:0] SPC_SLOT    = 8'h5D;
  localparam logic [7:0] SPC_TAG_RD  = 8'h5E;
  localparam logic [7:0] SPC_PRIV_LIM = 8'h80;

  localparam int unsigned VALID_BIT = 63;
  localparam int unsigned LOCK_BIT  = 6;
  localparam int unsigned REG_RO0   = 0;
  localparam int unsigned REG_FSTAT = 3;
  localparam int unsigned REG_FADDR = 4;
  localparam int unsigned REG_TAG   = 6;
  localparam logic [63:0] LSU_KEEP  = 64'h0000_0000_0000_000C;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_LSU_WR,
    OP_LSU_RD,
    OP_REG_WR,
    OP_REG_RD,
    OP_AUTO_WR,
    OP_SLOT_WR,
    OP_SLOT_RD,
    OP_TAG_RD,
    OP_ZERO_RD
  } tlb_op_e;
endpackage

// File: rtl/tlb_req_decode.sv
module tlb_req_decode
  import tlb_fill_pkg::*;
(
  input  logic       valid_i,
  input  logic       write_i,
  input  logic [7:0] space_i,
  input  logic       priv_i,
  output logic       trap_o,
  output tlb_op_e    op_o
);
  always_comb begin
    trap_o = valid_i && (space_i < SPC_PRIV_LIM) && !priv_i;
    op_o   = OP_NONE;
    if (valid_i && !trap_o) begin
      if (write_i) begin
        case (space_i)
          SPC_LSU_CTL: op_o = OP_LSU_WR;
          SPC_REGS:    op_o = OP_REG_WR;
          SPC_AUTO:    op_o = OP_AUTO_WR;
          SPC_SLOT:    op_o = OP_SLOT_WR;
          default:     op_o = OP_NONE;
        endcase
      end else begin
        case (space_i)
          SPC_LSU_CTL: op_o = OP_LSU_RD;
          SPC_REGS:    op_o = OP_REG_RD;
          SPC_SLOT:    op_o = OP_SLOT_RD;
          SPC_TAG_RD:  op_o = OP_TAG_RD;
          default:     op_o = OP_ZERO_RD;
        endcase
      end
    end
  end
endmodule

// File: rtl/tlb_first_one.sv
module tlb_first_one #(
  parameter int unsigned N = 64,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  bits_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int unsigned N = 64,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  valid_i,
  input  logic [N-1:0]  lock_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  logic          free_found, unl_found;
  logic [IW-1:0] free_idx, unl_idx;

  tlb_first_one #(.N(N)) u_free (
    .bits_i (~valid_i),
    .found_o(free_found),
    .idx_o  (free_idx)
  );

  tlb_first_one #(.N(N)) u_unlocked (
    .bits_i (~lock_i),
    .found_o(unl_found),
    .idx_o  (unl_idx)
  );

  assign hit_o = free_found || unl_found;
  assign idx_o = free_found ? free_idx : unl_idx;

  assert_victim_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&valid_i)) |-> !valid_i[idx_o] && hit_o);
  assert_victim_unlocked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&valid_i) && hit_o) |-> !lock_i[idx_o]);
  assert_no_victim_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&valid_i) && (&lock_i)) |-> !hit_o);
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_fill_pkg::*;
#(
  parameter int unsigned N = 64,
  parameter int unsigned W = 64,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_tag_i,
  input  logic [W-1:0]  wr_tte_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_tag_o,
  output logic [W-1:0]  rd_tte_o,
  output logic [N-1:0]  valid_o,
  output logic [N-1:0]  lock_o
);
  logic [W-1:0] tag_q [N];
  logic [W-1:0] tte_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        tag_q[i] <= '0;
        tte_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      tag_q[wr_idx_i] <= wr_tag_i;
      tte_q[wr_idx_i] <= wr_tte_i;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_flags
    assign valid_o[g] = tte_q[g][VALID_BIT];
    assign lock_o[g]  = tte_q[g][LOCK_BIT];
  end

  assign rd_tag_o = tag_q[rd_idx_i];
  assign rd_tte_o = tte_q[rd_idx_i];

  assert_slot_written_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (tte_q[$past(wr_idx_i)] == $past(wr_tte_i))
             && (tag_q[$past(wr_idx_i)] == $past(wr_tag_i)));
endmodule

// File: rtl/tlb_mmu_regs.sv
module tlb_mmu_regs
  import tlb_fill_pkg::*;
#(
  parameter int unsigned W    = 64,
  parameter int unsigned NREG = 16,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [RW-1:0] idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          fault_set_i,
  input  logic [W-1:0]  fault_status_i,
  input  logic [W-1:0]  fault_addr_i,
  output logic [W-1:0]  rd_data_o,
  output logic [W-1:0]  tag_o
);
  logic [W-1:0] regs_q [NREG];
  logic         fs_clear;

  assign fs_clear = wr_en_i && (idx_i == RW'(REG_FSTAT)) && !wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (fault_set_i && r == REG_FSTAT) begin
          regs_q[r] <= fault_status_i;
        end else if (fault_set_i && r == REG_FADDR) begin
          regs_q[r] <= fault_addr_i;
        end else if (r == REG_FADDR) begin
          if (fs_clear) regs_q[r] <= '0;
        end else if (wr_en_i && idx_i == RW'(r) && r != REG_RO0) begin
          if (r == REG_FSTAT) regs_q[r] <= wr_data_i[0] ? wr_data_i : '0;
          else                regs_q[r] <= wr_data_i;
        end
      end
    end
  end

  assign rd_data_o = regs_q[idx_i];
  assign tag_o     = regs_q[REG_TAG];

  assert_ro_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == RW'(REG_FADDR) && !fault_set_i) |=> $stable(regs_q[REG_FADDR]));
  assert_fstat_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_clear && !fault_set_i) |=> (regs_q[REG_FSTAT] == '0) && (regs_q[REG_FADDR] == '0));
  assert_fault_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_set_i |=> (regs_q[REG_FSTAT] == $past(fault_status_i))
                 && (regs_q[REG_FADDR] == $past(fault_addr_i)));
endmodule

// File: rtl/tlb_fill_unit.sv
module tlb_fill_unit
  import tlb_fill_pkg::*;
#(
  parameter int unsigned N    = 64,
  parameter int unsigned W    = 64,
  parameter int unsigned NREG = 16,
  localparam int unsigned IW  = $clog2(N),
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [7:0]    req_space_i,
  input  logic [IW-1:0] req_addr_i,
  input  logic [W-1:0]  req_wdata_i,
  input  logic          req_priv_i,
  input  logic          fault_set_i,
  input  logic [W-1:0]  fault_status_i,
  input  logic [W-1:0]  fault_addr_i,
  output logic          trap_o,
  output logic          rvalid_o,
  output logic [W-1:0]  rdata_o,
  output logic          flush_all_o
);
  tlb_op_e       op;
  logic          trap_d;
  logic [N-1:0]  valid_v, lock_v;
  logic          vict_hit;
  logic [IW-1:0] vict_idx;
  logic          arr_we;
  logic [IW-1:0] arr_widx;
  logic [W-1:0]  arr_tag, arr_tte, reg_rd, tag_stage;
  logic [W-1:0]  lsu_q, lsu_next;
  logic          lsu_change;
  logic [W-1:0]  rdata_d;

  tlb_req_decode u_dec (
    .valid_i(req_valid_i),
    .write_i(req_write_i),
    .space_i(req_space_i),
    .priv_i (req_priv_i),
    .trap_o (trap_d),
    .op_o   (op)
  );

  tlb_victim_sel #(.N(N)) u_vict (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_v),
    .lock_i (lock_v),
    .hit_o  (vict_hit),
    .idx_o  (vict_idx)
  );

  assign arr_we   = (op == OP_SLOT_WR) || (op == OP_AUTO_WR && vict_hit);
  assign arr_widx = (op == OP_AUTO_WR) ? vict_idx : req_addr_i;

  tlb_entry_array #(.N(N), .W(W)) u_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (arr_we),
    .wr_idx_i(arr_widx),
    .wr_tag_i(tag_stage),
    .wr_tte_i(req_wdata_i),
    .rd_idx_i(req_addr_i),
    .rd_tag_o(arr_tag),
    .rd_tte_o(arr_tte),
    .valid_o (valid_v),
    .lock_o  (lock_v)
  );

  tlb_mmu_regs #(.W(W), .NREG(NREG)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (op == OP_REG_WR),
    .idx_i         (req_addr_i[RW-1:0]),
    .wr_data_i     (req_wdata_i),
    .fault_set_i   (fault_set_i),
    .fault_status_i(fault_status_i),
    .fault_addr_i  (fault_addr_i),
    .rd_data_o     (reg_rd),
    .tag_o         (tag_stage)
  );

  assign lsu_next   = req_wdata_i & LSU_KEEP;
  assign lsu_change = (op == OP_LSU_WR) && (lsu_next != lsu_q);

  always_comb begin
    case (op)
      OP_LSU_RD:  rdata_d = lsu_q;
      OP_REG_RD:  rdata_d = reg_rd;
      OP_SLOT_RD: rdata_d = arr_tte;
      OP_TAG_RD:  rdata_d = arr_tag;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lsu_q       <= '0;
      trap_o      <= 1'b0;
      rvalid_o    <= 1'b0;
      rdata_o     <= '0;
      flush_all_o <= 1'b0;
    end else begin
      if (op == OP_LSU_WR) lsu_q <= lsu_next;
      trap_o      <= trap_d;
      rvalid_o    <= (op == OP_LSU_RD) || (op == OP_REG_RD) || (op == OP_SLOT_RD)
                  || (op == OP_TAG_RD) || (op == OP_ZERO_RD);
      rdata_o     <= rdata_d;
      flush_all_o <= lsu_change;
    end
  end

  assert_trap_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !rvalid_o && !flush_all_o);
  assert_flush_on_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_o |-> (lsu_q != $past(lsu_q)));
  assert_load_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_valid_i && !req_write_i));
endmodule

// File: tb/tlb_fill_unit_test.sv
module tlb_fill_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
  logic [7:0]  req_space = '0;
  logic [5:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        fault_set = 1'b0;
  logic [63:0] fault_status = '0, fault_addr = '0;
  logic        trap, rvalid, flush;
  logic [63:0] rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [63:0] m_tte [64];
  logic [63:0] m_tag [64];
  logic [63:0] m_reg [16];
  logic [63:0] m_lsu;

  localparam logic [63:0] VB = 64'h8000_0000_0000_0000;
  localparam logic [63:0] LB = 64'h0000_0000_0000_0040;

  always #4 clk = ~clk;

  tlb_fill_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_space_i(req_space),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_priv_i(req_priv),
    .fault_set_i(fault_set), .fault_status_i(fault_status), .fault_addr_i(fault_addr),
    .trap_o(trap), .rvalid_o(rvalid), .rdata_o(rdata), .flush_all_o(flush)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic [7:0] sp, input logic [63:0] a,
                      input logic [63:0] d, input logic pr, input logic fs,
                      input logic [63:0] fst, input logic [63:0] fad, input string req);
    logic e_trap, e_rv, e_fl;
    logic [63:0] e_rd, nl;
    int slot, ri;
    req_valid = v; req_write = w; req_space = sp; req_addr = a[8:3];
    req_wdata = d; req_priv = pr; fault_set = fs; fault_status = fst; fault_addr = fad;
    e_trap = v && (sp < 8'h80) && !pr;
    e_rv = v && !w && !e_trap;
    e_fl = 1'b0;
    e_rd = '0;
    ri = int'(a[6:3]);
    slot = int'(a[8:3]);
    if (e_rv) begin
      case (sp)
        8'h45: e_rd = m_lsu;
        8'h58: e_rd = m_reg[ri];
        8'h5D: e_rd = m_tte[slot];
        8'h5E: e_rd = m_tag[slot];
        default: e_rd = '0;
      endcase
    end
    if (v && w && !e_trap) begin
      case (sp)
        8'h45: begin nl = d & 64'hC; e_fl = (nl != m_lsu); m_lsu = nl; end
        8'h58: begin
          if (ri == 3) begin
            m_reg[3] = d[0] ? d : 64'd0;
            if (!d[0]) m_reg[4] = 64'd0;
          end else if (ri != 0 && ri != 4) m_reg[ri] = d;
        end
        8'h5C: begin
          int pick = -1;
          for (int i = 0; i < 64; i++) if (pick < 0 && !m_tte[i][63]) pick = i;
          for (int i = 0; i < 64; i++) if (pick < 0 && !m_tte[i][6]) pick = i;
          if (pick >= 0) begin m_tte[pick] = d; m_tag[pick] = m_reg[6]; end
        end
        8'h5D: begin m_tte[slot] = d; m_tag[slot] = m_reg[6]; end
        default: ;
      endcase
    end
    if (fs) begin m_reg[3] = fst; m_reg[4] = fad; end
    @(posedge clk);
    @(negedge clk);
    chk({63'd0, trap}, {63'd0, e_trap}, req, "trap_o");
    chk({63'd0, rvalid}, {63'd0, e_rv}, req, "rvalid_o");
    chk({63'd0, flush}, {63'd0, e_fl}, req, "flush_all_o");
    if (e_rv) chk(rdata, e_rd, req, "rdata_o");
    req_valid = 1'b0; fault_set = 1'b0;
  endtask

  task automatic st(input logic [7:0] sp, input logic [63:0] a, input logic [63:0] d, input string req);
    step(1'b1, 1'b1, sp, a, d, 1'b1, 1'b0, 64'd0, 64'd0, req);
  endtask

  task automatic ld(input logic [7:0] sp, input logic [63:0] a, input string req);
    step(1'b1, 1'b0, sp, a, 64'd0, 1'b1, 1'b0, 64'd0, 64'd0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_tte[i] = '0; m_tag[i] = '0; end
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    m_lsu = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    step(1'b0, 1'b0, 8'h0, 64'd0, 64'd0, 1'b1, 1'b0, 64'd0, 64'd0, "R1");
    ld(8'h5D, 64'd0, "R1");
    ld(8'h5E, 64'(63 << 3), "R1");
    ld(8'h58, 64'(6 << 3), "R1");
    ld(8'h45, 64'd0, "R1");

    // R6 register bank
    st(8'h58, 64'(6 << 3), 64'hA5A5_0000_0000_1000, "R6");
    st(8'h58, 64'(0 << 3), 64'hFFFF, "R6");
    st(8'h58, 64'(4 << 3), 64'h1234, "R6");
    st(8'h58, 64'(5 << 3), 64'h5555_AAAA, "R6");
    for (int r = 0; r < 16; r++) ld(8'h58, 64'(r << 3), "R6");

    // R2 automatic fill into empty slots
    for (int k = 0; k < 3; k++) st(8'h5C, 64'd0, VB | 64'(k + 16), "R2");
    for (int s = 0; s < 4; s++) begin ld(8'h5D, 64'(s << 3), "R2"); ld(8'h5E, 64'(s << 3), "R2"); end
    // R5 direct slot write invalidates slot 1, R2 refills lowest hole
    st(8'h58, 64'(6 << 3), 64'hBEEF_0000_0000_2000, "R5");
    st(8'h5D, 64'(1 << 3), 64'd0, "R5");
    st(8'h5D, 64'(40 << 3), VB | 64'h77, "R5");
    ld(8'h5D, 64'(40 << 3), "R5");
    ld(8'h5E, 64'(40 << 3), "R5");
    st(8'h5C, 64'd0, VB | 64'h99, "R2");
    ld(8'h5D, 64'(1 << 3), "R2");
    ld(8'h5E, 64'(1 << 3), "R2");

    // R3 full buffer, locked prefix
    for (int s = 0; s < 64; s++) st(8'h5D, 64'(s << 3), VB | (s < 10 ? LB : 64'd0) | 64'(s << 12), "R3");
    st(8'h58, 64'(6 << 3), 64'hC0DE, "R3");
    st(8'h5C, 64'd0, VB | 64'hABC, "R3");
    for (int s = 8; s < 12; s++) begin ld(8'h5D, 64'(s << 3), "R3"); ld(8'h5E, 64'(s << 3), "R3"); end

    // R4 full and locked: store dropped
    for (int s = 0; s < 64; s++) st(8'h5D, 64'(s << 3), VB | LB | 64'(s), "R4");
    st(8'h5C, 64'd0, VB | 64'hDEAD, "R4");
    for (int s = 0; s < 64; s++) ld(8'h5D, 64'(s << 3), "R4");

    // R7 fault status clearing
    step(1'b0, 1'b0, 8'h0, 64'd0, 64'd0, 1'b1, 1'b1, 64'h1F1, 64'hDEAD_0000, "R10");
    ld(8'h58, 64'(3 << 3), "R10");
    ld(8'h58, 64'(4 << 3), "R10");
    st(8'h58, 64'(3 << 3), 64'h55, "R7");
    ld(8'h58, 64'(3 << 3), "R7");
    ld(8'h58, 64'(4 << 3), "R7");
    st(8'h58, 64'(3 << 3), 64'h54, "R7");
    ld(8'h58, 64'(3 << 3), "R7");
    ld(8'h58, 64'(4 << 3), "R7");

    // R10 capture collides with a clearing store, then with an unrelated store
    step(1'b1, 1'b1, 8'h58, 64'(3 << 3), 64'h0, 1'b1, 1'b1, 64'h3A3, 64'hF00D, "R10");
    ld(8'h58, 64'(3 << 3), "R10");
    ld(8'h58, 64'(4 << 3), "R10");
    step(1'b1, 1'b1, 8'h58, 64'(5 << 3), 64'h6161, 1'b1, 1'b1, 64'h7B7, 64'hCAFE, "R10");
    for (int r = 3; r < 6; r++) ld(8'h58, 64'(r << 3), "R10");

    // R8 unprivileged access
    step(1'b1, 1'b1, 8'h58, 64'(5 << 3), 64'h9999, 1'b0, 1'b0, 64'd0, 64'd0, "R8");
    step(1'b1, 1'b0, 8'h58, 64'(5 << 3), 64'd0, 1'b0, 1'b0, 64'd0, 64'd0, "R8");
    step(1'b1, 1'b1, 8'h5D, 64'(2 << 3), 64'd0, 1'b0, 1'b0, 64'd0, 64'd0, "R8");
    step(1'b1, 1'b1, 8'h45, 64'd0, 64'hC, 1'b0, 1'b0, 64'd0, 64'd0, "R8");
    ld(8'h58, 64'(5 << 3), "R8");
    ld(8'h5D, 64'(2 << 3), "R8");
    step(1'b1, 1'b0, 8'h90, 64'd0, 64'd0, 1'b0, 1'b0, 64'd0, 64'd0, "R11");

    // R9 enable state and flush
    st(8'h45, 64'd0, 64'hFF, "R9");
    ld(8'h45, 64'd0, "R9");
    st(8'h45, 64'd0, 64'h0C, "R9");
    st(8'h45, 64'd0, 64'h04, "R9");
    ld(8'h45, 64'd0, "R9");

    // R11 other spaces load zero
    ld(8'h20, 64'd0, "R11");
    ld(8'h5C, 64'd0, "R11");
    step(1'b0, 1'b0, 8'h0, 64'd0, 64'd0, 1'b1, 1'b0, 64'd0, 64'd0, "R11");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule